// File: doc/BRIEF.md
# Deferred floating-point exception signaller

This controller sits next to a floating-point datapath and decides when a numeric exception reaches software. The datapath reports the exceptions each instruction raised. The block folds those reports into six sticky flags and a summary error bit. It watches the classified stream of instructions at issue and holds back the first instruction that has to see a pending exception.

In internal mode it raises a trap request with a fixed vector number while it holds that instruction. In legacy mode it raises no trap. Instead it drives an error pin and waits for the system either to acknowledge the interrupt or to assert the ignore-error input.

Instructions that do not wait are never held. This lets a handler read the status, save state or clear the flags while the exception is still pending. The pending state stays set until an init or clear instruction wipes the flags. Taking a trap does not clear it.

Top module: `fpx_signaller`

## Requirements
- R1: While rst_ni is low, flags_o and err_sum_o are zero, and stall_o, trap_req_o and err_pin_o are low.
- R2: A det_valid_i cycle ORs det_flags_i into flags_o at the next clock edge. Several bits may be set in one report. The flags are sticky whether their mask bits are set or clear. Bit positions: 0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 precision. mask_i uses the same positions, and a bit value of 1 means masked.
- R3: err_sum_o becomes 1 after a report that contains at least one unmasked bit. It then stays 1 until a clear is accepted. A report whose bits are all masked does not set it.
- R4: An accepted instruction of class 5 (init or clear) zeroes flags_o and err_sum_o at the next edge. A report made in the same cycle is still recorded after the clear.
- R5: "Pending" means that flags_o ANDed with the inverse of mask_i is nonzero. Some instructions are waiting instructions: class 1 (waiting FP), class 3 (wait) and class 4 (SIMD-integer). In internal mode (native_mode_i=1), a valid waiting instruction presented while an exception is pending drives stall_o=1 and ins_go_o=0, for as long as the exception stays pending.
- R6: In internal mode, trap_req_o is high only in the first cycle of each stall episode. While trap_req_o is high, trap_vec_o equals 16.
- R7: Valid instructions of class 2 (store status, store control, store environment, save state) and class 5 are never stalled. ins_go_o is high for them in every mode. Classes 0, 6 and 7 also always proceed.
- R8: In legacy mode (native_mode_i=0), trap_req_o stays low. err_pin_o equals the value of (legacy mode AND pending) one cycle earlier.
- R9: In legacy mode, a valid waiting instruction is stalled while an exception is pending. The stall is skipped in any cycle where ignore_err_i or intr_ack_i is high. In that cycle the instruction proceeds and no trap is raised.
- R10: With nothing pending, every valid instruction proceeds in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| native_mode_i | input | 1 | 1 selects internal trapping, 0 selects the legacy pin scheme |
| mask_i | input | NEXC | Exception mask bits, 1 = masked |
| det_valid_i | input | 1 | Exception report from the datapath is valid |
| det_flags_i | input | NEXC | Exceptions raised by the reporting instruction |
| ins_valid_i | input | 1 | Instruction at issue is valid |
| ins_class_i | input | 3 | Instruction class code |
| intr_ack_i | input | 1 | External interrupt acknowledge (legacy mode) |
| ignore_err_i | input | 1 | Ignore-error input (legacy mode) |
| ins_go_o | output | 1 | Instruction at issue proceeds this cycle |
| stall_o | output | 1 | Instruction at issue is held |
| trap_req_o | output | 1 | Internal trap request pulse |
| trap_vec_o | output | VEC_W | Trap vector number |
| err_pin_o | output | 1 | Error pin (legacy mode) |
| flags_o | output | NEXC | Sticky exception flags |
| err_sum_o | output | 1 | Summary error flag |

## Verification
The bench builds the block with its defaults: six flags, an 8-bit vector field and vector 16. With six flags it can report a masked denormal and underflow together, and it can mask a single bit while another is unmasked. It can also give a flag a report in the same cycle as a clear. The full vector value is compared on every trap pulse. Both modes run against the same flag history. This places a legacy stall, an acknowledge release and an ignore release next to internal stalls on each of the three waiting classes.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE   = 3'd0,
    CLS_WFP    = 3'd1,
    CLS_NOWAIT = 3'd2,
    CLS_WAIT   = 3'd3,
    CLS_SIMD   = 3'd4,
    CLS_CLEAR  = 3'd5
  } ins_cls_e;

  function automatic logic cls_waits(input logic [CLS_W-1:0] c);
    return (c == CLS_WFP) || (c == CLS_WAIT) || (c == CLS_SIMD);
  endfunction
endpackage

// File: rtl/fpx_flags.sv
module fpx_flags #(
  parameter int unsigned NEXC = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            det_valid_i,
  input  logic [NEXC-1:0] det_flags_i,
  input  logic [NEXC-1:0] mask_i,
  input  logic            clear_i,
  output logic [NEXC-1:0] flags_o,
  output logic            err_sum_o,
  output logic            pending_o
);
  logic [NEXC-1:0] flags_q, flags_d, det_m;
  logic            sum_q, sum_d;

  assign det_m = det_valid_i ? det_flags_i : '0;

  always_comb begin
    flags_d = clear_i ? '0 : flags_q;
    sum_d   = clear_i ? 1'b0 : sum_q;
    // report lands after the clear
    flags_d = flags_d | det_m;
    sum_d   = sum_d | (|(det_m & ~mask_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      sum_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      sum_q   <= sum_d;
    end
  end

  assign flags_o   = flags_q;
  assign err_sum_o = sum_q;
  assign pending_o = |(flags_q & ~mask_i);
endmodule

// File: rtl/fpx_gate.sv
module fpx_gate
  import fpx_pkg::*;
#(
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned TRAP_VEC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             native_i,
  input  logic             pending_i,
  input  logic             valid_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic             ack_i,
  input  logic             ignore_i,
  output logic             go_o,
  output logic             stall_o,
  output logic             clear_o,
  output logic             trap_req_o,
  output logic [VEC_W-1:0] trap_vec_o
);
  localparam logic [VEC_W-1:0] VEC = VEC_W'(TRAP_VEC);

  logic waits, blk_native, blk_legacy, sent_q;

  assign waits      = valid_i && cls_waits(cls_i) && pending_i;
  assign blk_native = native_i && waits;
  assign blk_legacy = !native_i && waits && !ignore_i && !ack_i;

  assign stall_o = blk_native || blk_legacy;
  assign go_o    = valid_i && !stall_o;
  assign clear_o = go_o && (cls_i == CLS_CLEAR);

  // one pulse per stall episode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sent_q <= 1'b0;
    else         sent_q <= blk_native;
  end

  assign trap_req_o = blk_native && !sent_q;
  assign trap_vec_o = VEC;
endmodule

// File: rtl/fpx_errpin.sv
module fpx_errpin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic native_i,
  input  logic pending_i,
  output logic err_pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= !native_i && pending_i;
  end

  assign err_pin_o = pin_q;
endmodule

// File: rtl/fpx_signaller.sv
module fpx_signaller
  import fpx_pkg::*;
#(
  parameter int unsigned NEXC     = 6,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned TRAP_VEC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             native_mode_i,
  input  logic [NEXC-1:0]  mask_i,
  input  logic             det_valid_i,
  input  logic [NEXC-1:0]  det_flags_i,
  input  logic             ins_valid_i,
  input  logic [CLS_W-1:0] ins_class_i,
  input  logic             intr_ack_i,
  input  logic             ignore_err_i,
  output logic             ins_go_o,
  output logic             stall_o,
  output logic             trap_req_o,
  output logic [VEC_W-1:0] trap_vec_o,
  output logic             err_pin_o,
  output logic [NEXC-1:0]  flags_o,
  output logic             err_sum_o
);
  logic pending, clear;

  fpx_flags #(.NEXC(NEXC)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .det_valid_i (det_valid_i),
    .det_flags_i (det_flags_i),
    .mask_i      (mask_i),
    .clear_i     (clear),
    .flags_o     (flags_o),
    .err_sum_o   (err_sum_o),
    .pending_o   (pending)
  );

  fpx_gate #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .native_i   (native_mode_i),
    .pending_i  (pending),
    .valid_i    (ins_valid_i),
    .cls_i      (ins_class_i),
    .ack_i      (intr_ack_i),
    .ignore_i   (ignore_err_i),
    .go_o       (ins_go_o),
    .stall_o    (stall_o),
    .clear_o    (clear),
    .trap_req_o (trap_req_o),
    .trap_vec_o (trap_vec_o)
  );

  fpx_errpin u_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .native_i  (native_mode_i),
    .pending_i (pending),
    .err_pin_o (err_pin_o)
  );
endmodule

// File: rtl/fpx_signaller_chk.sv
module fpx_signaller_chk
  import fpx_pkg::*;
#(
  parameter int unsigned NEXC     = 6,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned TRAP_VEC = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             native_mode_i,
  input logic [NEXC-1:0]  mask_i,
  input logic [CLS_W-1:0] ins_class_i,
  input logic             ins_valid_i,
  input logic             ins_go_o,
  input logic             stall_o,
  input logic             trap_req_o,
  input logic [VEC_W-1:0] trap_vec_o,
  input logic             err_pin_o,
  input logic [NEXC-1:0]  flags_o,
  input logic             err_sum_o
);
  logic pend;
  assign pend = |(flags_o & ~mask_i);

  a_r5_stall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ins_valid_i && cls_waits(ins_class_i) && pend && !ins_go_o));

  a_r7_nowait_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && (ins_class_i == CLS_NOWAIT || ins_class_i == CLS_CLEAR)) |-> ins_go_o);

  a_r10_idle_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !pend) |-> ins_go_o);

  a_r6_trap_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> (trap_vec_o == VEC_W'(TRAP_VEC) && stall_o && native_mode_i));

  a_r6_trap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |=> !trap_req_o);

  a_r8_no_legacy_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !native_mode_i |-> !trap_req_o);

  a_r8_pin_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (err_pin_o == ($past(!native_mode_i) && $past(pend))));

  a_r2_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ins_go_o && ins_class_i == CLS_CLEAR) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  a_r3_sum_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_sum_o && !(ins_go_o && ins_class_i == CLS_CLEAR)) |=> err_sum_o);
endmodule

bind fpx_signaller fpx_signaller_chk #(.NEXC(NEXC), .VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .native_mode_i (native_mode_i),
  .mask_i        (mask_i),
  .ins_class_i   (ins_class_i),
  .ins_valid_i   (ins_valid_i),
  .ins_go_o      (ins_go_o),
  .stall_o       (stall_o),
  .trap_req_o    (trap_req_o),
  .trap_vec_o    (trap_vec_o),
  .err_pin_o     (err_pin_o),
  .flags_o       (flags_o),
  .err_sum_o     (err_sum_o)
);

// File: tb/tb_fpx_signaller.sv
module tb_fpx_signaller;
  localparam int NEXC = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic native_mode_i = 1'b1;
  logic [NEXC-1:0] mask_i = '1, det_flags_i = '0;
  logic det_valid_i = 1'b0, ins_valid_i = 1'b0, intr_ack_i = 1'b0, ignore_err_i = 1'b0;
  logic [2:0] ins_class_i = 3'd0;
  logic ins_go_o, stall_o, trap_req_o, err_pin_o, err_sum_o;
  logic [7:0] trap_vec_o;
  logic [NEXC-1:0] flags_o;

  int checks = 0, failures = 0, cycles = 0;
  logic [NEXC-1:0] m_flags = '0;
  bit m_sum = 0, m_pin = 0, m_sent = 0;

  always #5 clk = ~clk;

  fpx_signaller dut (
    .clk_i(clk), .rst_ni(rst_ni), .native_mode_i(native_mode_i), .mask_i(mask_i),
    .det_valid_i(det_valid_i), .det_flags_i(det_flags_i), .ins_valid_i(ins_valid_i),
    .ins_class_i(ins_class_i), .intr_ack_i(intr_ack_i), .ignore_err_i(ignore_err_i),
    .ins_go_o(ins_go_o), .stall_o(stall_o), .trap_req_o(trap_req_o), .trap_vec_o(trap_vec_o),
    .err_pin_o(err_pin_o), .flags_o(flags_o), .err_sum_o(err_sum_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive, compare with model, clock, advance model
  task automatic step(input bit nat, input logic [NEXC-1:0] msk, input bit dv,
                      input logic [NEXC-1:0] df, input bit iv, input int cls,
                      input bit ack = 0, input bit ign = 0);
    bit pend, wt, blk, trp, go, clr;
    string tg_s, tg_t, tg_f;
    native_mode_i = nat; mask_i = msk; det_valid_i = dv; det_flags_i = df;
    ins_valid_i = iv; ins_class_i = 3'(cls); intr_ack_i = ack; ignore_err_i = ign;
    #1;
    pend = |(m_flags & ~msk);
    wt   = iv && (cls == 1 || cls == 3 || cls == 4);
    blk  = wt && pend && (nat || (!ign && !ack));
    trp  = nat && blk && !m_sent;
    go   = iv && !blk;
    if (!wt) tg_s = "R7";
    else if (!pend) tg_s = "R10";
    else tg_s = nat ? "R5" : "R9";
    tg_t = nat ? "R6" : "R8";
    chk({tg_s, " stall"}, int'(stall_o), int'(blk));
    chk({tg_s, " go"}, int'(ins_go_o), int'(go));
    chk({tg_t, " trap"}, int'(trap_req_o), int'(trp));
    if (trap_req_o) chk("R6 vector", int'(trap_vec_o), 16);
    tg_f = "R2";
    chk({tg_f, " flags"}, int'(flags_o), int'(m_flags));
    chk("R3 summary", int'(err_sum_o), int'(m_sum));
    chk("R8 pin", int'(err_pin_o), int'(m_pin));
    clr = go && cls == 5;
    @(posedge clk);
    m_flags = (clr ? '0 : m_flags) | (dv ? df : '0);
    m_sum   = (clr ? 1'b0 : m_sum) | (dv && |(df & ~msk));
    m_pin   = !nat && pend;
    m_sent  = nat && blk;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags", int'(flags_o), 0);
    chk("R1 sum", int'(err_sum_o), 0);
    chk("R1 stall", int'(stall_o), 0);
    chk("R1 trap", int'(trap_req_o), 0);
    chk("R1 pin", int'(err_pin_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: masked denormal+underflow in one report, no trap on following waiting FP
    step(1, 6'h3F, 1, 6'h12, 1, 1);
    step(1, 6'h3F, 0, 0, 1, 1);
    step(1, 6'h3F, 0, 0, 1, 3);
    // R4: clear with everything unmasked (old flags now pending, clear still runs)
    step(1, 6'h00, 0, 0, 1, 5);
    step(1, 6'h00, 0, 0, 1, 3);           // R10
    // R3/R7: unmasked divide-by-zero, non-waiting instructions proceed
    step(1, 6'h00, 1, 6'h04, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 6'h00, 0, 0, 1, 2);
    // R5/R6: wait instruction stalls, single trap pulse
    for (int i = 0; i < 4; i++) step(1, 6'h00, 0, 0, 1, 3);
    step(1, 6'h00, 0, 0, 1, 5);           // handler clears
    step(1, 6'h00, 0, 0, 1, 3);           // now proceeds
    // SIMD-integer class blocked
    step(1, 6'h00, 1, 6'h01, 0, 0);
    for (int i = 0; i < 2; i++) step(1, 6'h00, 0, 0, 1, 4);
    step(1, 6'h00, 0, 0, 0, 0);
    step(1, 6'h00, 0, 0, 1, 4);           // new episode, new pulse
    step(1, 6'h00, 0, 0, 1, 5);
    // waiting FP blocked on overflow
    step(1, 6'h00, 1, 6'h08, 0, 0);
    for (int i = 0; i < 2; i++) step(1, 6'h00, 0, 0, 1, 1);
    // R4: clear and precision report in the same cycle
    step(1, 6'h00, 1, 6'h20, 1, 5);
    step(1, 6'h00, 0, 0, 1, 2);
    // R8/R9: legacy mode, stall then ack release
    step(0, 6'h00, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 6'h00, 0, 0, 1, 1);
    step(0, 6'h00, 0, 0, 1, 1, 1, 0);
    // R9 ignore path
    step(0, 6'h00, 0, 0, 1, 3, 0, 1);
    step(0, 6'h00, 0, 0, 1, 4, 0, 1);
    step(0, 6'h00, 0, 0, 1, 2);
    step(0, 6'h00, 0, 0, 1, 5);
    step(0, 6'h00, 0, 0, 0, 0);           // pin drops
    step(0, 6'h00, 0, 0, 1, 1);
    // partial masking: invalid masked, overflow unmasked
    step(1, 6'h01, 1, 6'h01, 1, 1);
    step(1, 6'h01, 0, 0, 1, 1);
    step(1, 6'h01, 1, 6'h08, 0, 0);
    step(1, 6'h01, 0, 0, 1, 1);
    step(1, 6'h01, 0, 0, 1, 6);           // R7 reserved codes
    step(1, 6'h01, 0, 0, 1, 7);
    step(1, 6'h01, 0, 0, 1, 5);
    step(1, 6'h01, 0, 0, 1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule